// File: doc/BRIEF.md
# Block Transfer Sequencer for 16-bit Multi-Register Load/Store

This block carries out a multi-register load or store encoded in a 16-bit instruction halfword. On a start pulse it reads the base register and captures an eight-bit register list. It then walks the list from the lowest index upward. For each selected low register it moves one 32-bit word between that register and memory, at consecutive word addresses that begin at the base value. When the list is exhausted it writes the final address back to the base register and pulses done.

Two corner cases are defined. An empty list moves the program counter (register 15) instead of a list register, and the base advances by 0x40. A store whose base register is also in the list stores either the original base or the final written-back address. Which one depends on whether the base is the lowest listed register.

The controller is a five-state machine:
- IDLE waits for start. It moves to SCAN, or straight to XFER for an empty list.
- SCAN picks the lowest pending list bit and moves to XFER. When nothing is pending it moves to WBACK.
- XFER holds one memory request until ready and then returns to SCAN.
- WBACK writes the base register and moves to FIN.
- FIN raises done for one cycle and returns to IDLE.

Top module: `lsm_seq`

## Requirements
- R1: The instruction halfword is decoded as follows. Bit 11 selects load (1) or store (0). Bits 10:8 give the base register index. Bits 7:0 are the register list, where bit k selects register k.
- R2: Listed registers are transferred in ascending index order. The first word address equals the base value, and each following word address is 4 higher than the one before.
- R3: On a load, each listed register receives the memory word at its slot address.
- R4: On a store, the memory word at each slot address receives the value of its listed register. The register file is not written during a store's memory phase.
- R5: After a non-empty transfer, the base register holds the base value plus 4 times the number of listed registers.
- R6: On a store with the base register in the list, the base's slot receives the original base value when the base is the lowest listed register. Otherwise it receives the final written-back address.
- R7: On a load with the base register in the list, the base register ends holding the written-back address, not the loaded word.
- R8: With an empty list, a load places the word at the base address into register 15, and the base becomes the base plus 0x40.
- R9: With an empty list, a store writes register 15 plus 2 to the base address, and the base becomes the base plus 0x40.
- R10: A memory request holds its address and direction unchanged until the cycle in which ready is high.
- R11: done_o is high for exactly one cycle. That cycle immediately follows the base writeback. busy_o is high from the cycle after start until done.
- R12: A start pulse that arrives while busy_o is high has no effect on memory, on the register file or on the number of done pulses.
- R13: Out of reset the block is idle. busy_o, done_o, mem_req_o and rf_wr_en_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled only in IDLE |
| instr_i | input | 16 | Instruction halfword |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rf_rd_idx_o | output | 4 | Register file read index |
| rf_rd_data_i | input | 32 | Register file read data (combinational) |
| rf_wr_en_o | output | 1 | Register file write enable |
| rf_wr_idx_o | output | 4 | Register file write index |
| rf_wr_data_o | output | 32 | Register file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory ready; completes the current request |

## Verification
The embedded assertions check four things on every cycle:
- a stalled request keeps its address and direction;
- done is a single-cycle pulse that directly follows a register write;
- a store never writes the register file;
- an idle block issues neither memory requests nor register writes.

The values moved are a different matter. Ascending order, the base-in-list choice between original and final address, the empty-list program-counter transfer and the rejection of a start while busy can only be shown by the bench. It sweeps every list for both directions and every base register, stalls ready at random, and compares the final register file and memory with arithmetic expectations.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCAN  = 3'd1,
        ST_XFER  = 3'd2,
        ST_WBACK = 3'd3,
        ST_FIN   = 3'd4
    } lsm_state_e;
endpackage

// File: rtl/lsm_lowest.sv
module lsm_lowest #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Highest-to-lowest scan so the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        any_o = |vec_i;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
    parameter int DATA_W    = 32,
    parameter int LIST_W    = 8,
    parameter int RIDX_W    = 4,
    parameter int INSTR_W   = 16,
    parameter int PC_IDX    = 15,
    parameter int WORD_STEP = 4,
    parameter int EMPTY_ADV = 64,
    parameter int PC_ADJ    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [RIDX_W-1:0]  rf_rd_idx_o,
    input  logic [DATA_W-1:0]  rf_rd_data_i,
    output logic               rf_wr_en_o,
    output logic [RIDX_W-1:0]  rf_wr_idx_o,
    output logic [DATA_W-1:0]  rf_wr_data_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [DATA_W-1:0]  mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    input  logic               mem_ready_i
);
    import lsm_pkg::*;

    localparam int BASE_W   = $clog2(LIST_W);
    localparam int CNT_W    = $clog2(LIST_W + 1);
    localparam int LOAD_POS = LIST_W + BASE_W;

    lsm_state_e state_q, state_d;

    logic              load_q;
    logic              empty_q;
    logic [BASE_W-1:0] base_idx_q;
    logic [BASE_W-1:0] first_idx_q;
    logic [LIST_W-1:0] pend_q;
    logic [RIDX_W-1:0] cur_idx_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] final_q;

    // Instruction field split (R1)
    logic [LIST_W-1:0] in_list;
    logic [BASE_W-1:0] in_base;
    logic              in_load;
    assign in_list = instr_i[LIST_W-1:0];
    assign in_base = instr_i[LIST_W +: BASE_W];
    assign in_load = instr_i[LOAD_POS];

    // Lowest-bit finders: one on the incoming list, one on the pending set
    logic [LIST_W-1:0] scan_vec [2];
    logic [BASE_W-1:0] scan_idx [2];
    logic              scan_any [2];
    assign scan_vec[0] = in_list;
    assign scan_vec[1] = pend_q;

    for (genvar g = 0; g < 2; g++) begin : g_find
        lsm_lowest #(.W(LIST_W), .IW(BASE_W)) u_low (
            .vec_i (scan_vec[g]),
            .idx_o (scan_idx[g]),
            .any_o (scan_any[g])
        );
    end

    logic [CNT_W-1:0] in_cnt;
    lsm_popcnt #(.W(LIST_W), .CW(CNT_W)) u_cnt (
        .vec_i (in_list),
        .cnt_o (in_cnt)
    );

    logic [LIST_W-1:0] cur_mask;
    assign cur_mask = LIST_W'(1) << cur_idx_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = (in_list == '0) ? ST_XFER : ST_SCAN;
            ST_SCAN:  state_d = scan_any[1] ? ST_XFER : ST_WBACK;
            ST_XFER:  if (mem_ready_i) state_d = ST_SCAN;
            ST_WBACK: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q      <= 1'b0;
            empty_q     <= 1'b0;
            base_idx_q  <= '0;
            first_idx_q <= '0;
            pend_q      <= '0;
            cur_idx_q   <= '0;
            addr_q      <= '0;
            final_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    load_q      <= in_load;
                    empty_q     <= (in_list == '0);
                    base_idx_q  <= in_base;
                    first_idx_q <= scan_idx[0];
                    pend_q      <= in_list;
                    cur_idx_q   <= RIDX_W'(PC_IDX);
                    addr_q      <= rf_rd_data_i;
                    final_q     <= rf_rd_data_i + ((in_list == '0) ? DATA_W'(EMPTY_ADV)
                                                 : DATA_W'(in_cnt) * DATA_W'(WORD_STEP));
                end
                ST_SCAN: if (scan_any[1]) cur_idx_q <= RIDX_W'(scan_idx[1]);
                ST_XFER: if (mem_ready_i) begin
                    pend_q <= pend_q & ~cur_mask;
                    addr_q <= addr_q + DATA_W'(WORD_STEP);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    logic store_final;
    assign store_final = (cur_idx_q == RIDX_W'(base_idx_q)) && (base_idx_q != first_idx_q);

    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = 1'b0;
        rf_rd_idx_o  = cur_idx_q;
        rf_wr_en_o   = 1'b0;
        rf_wr_idx_o  = cur_idx_q;
        rf_wr_data_o = mem_rdata_i;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = addr_q;
        mem_wdata_o  = rf_rd_data_i;
        unique case (state_q)
            ST_IDLE: rf_rd_idx_o = RIDX_W'(in_base);
            ST_SCAN: ;
            ST_XFER: begin
                mem_req_o  = 1'b1;
                mem_we_o   = !load_q;
                rf_wr_en_o = load_q && mem_ready_i;
                if (empty_q)          mem_wdata_o = rf_rd_data_i + DATA_W'(PC_ADJ);
                else if (store_final) mem_wdata_o = final_q;
            end
            ST_WBACK: begin
                rf_wr_en_o   = 1'b1;
                rf_wr_idx_o  = RIDX_W'(base_idx_q);
                rf_wr_data_o = final_q;
            end
            ST_FIN:  done_o = 1'b1;
            default: ;
        endcase
    end

    // Assertions
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rf_wr_en_o));

    assert_store_no_rfwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !rf_wr_en_o);

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !rf_wr_en_o && !done_o));
endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic        busy_o, done_o;
    logic [3:0]  rf_rd_idx_o, rf_wr_idx_o;
    logic [31:0] rf_rd_data_i, rf_wr_data_o;
    logic        rf_wr_en_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_ready_i = 1'b0;

    logic [31:0] rf_m  [16];
    logic [31:0] mem_m [64];

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    bit finished = 0;
    logic [31:0] exp_addr = '0;
    bit          exp_we = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;

    always #10 clk = ~clk;

    assign rf_rd_data_i = rf_m[rf_rd_idx_o];
    assign mem_rdata_i  = mem_m[mem_addr_o[7:2]];

    lsm_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .busy_o(busy_o), .done_o(done_o),
        .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i),
        .rf_wr_en_o(rf_wr_en_o), .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i)
    );

    // Ready generator: pseudo-random stalls, changed just after each rising edge
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready_i = lfsr[0] | lfsr[3];
        end
    end

    // Memory / register-file model and per-access checks, on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                checks++;
                if (!(mem_req_o && mem_addr_o == prev_addr)) begin
                    fails++;
                    $display("FAIL R10 stalled request: req=%0b addr=%h expected req=1 addr=%h",
                             mem_req_o, mem_addr_o, prev_addr);
                end
            end
            prev_stall = mem_req_o && !mem_ready_i;
            prev_addr  = mem_addr_o;
            if (mem_req_o && mem_ready_i) begin
                checks++;
                if (mem_addr_o !== exp_addr || mem_we_o !== exp_we) begin
                    fails++;
                    $display("FAIL R1/R2 access: addr=%h we=%0b expected addr=%h we=%0b",
                             mem_addr_o, mem_we_o, exp_addr, exp_we);
                end
                exp_addr = exp_addr + 32'd4;
                if (mem_we_o) mem_m[mem_addr_o[7:2]] = mem_wdata_o;
            end
            if (rf_wr_en_o) rf_m[rf_wr_idx_o] = rf_wr_data_o;
            if (done_o) done_cnt++;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit ld, input int b, input int lst, input bit inject);
        logic [31:0] erf [16];
        logic [31:0] emem [64];
        logic [31:0] base, fin, a;
        int cnt, low, bad_r, bad_m;
        string rtag, mtag;
        for (int i = 0; i < 16; i++) rf_m[i] = 32'hA500_0000 | (i << 16) | (lst << 4) | b;
        rf_m[15] = 32'h0800_1234 + lst;
        rf_m[b]  = 32'((lst * 4 + b * 12) & 8'hFC);
        for (int i = 0; i < 64; i++) mem_m[i] = 32'h5A00_0000 | (i << 8) | lst;
        for (int i = 0; i < 16; i++) erf[i] = rf_m[i];
        for (int i = 0; i < 64; i++) emem[i] = mem_m[i];
        base = rf_m[b];
        cnt = 0; low = -1;
        for (int k = 0; k < 8; k++) if (lst[k]) begin cnt++; if (low < 0) low = k; end
        fin = (cnt == 0) ? base + 32'h40 : base + 32'(4 * cnt);
        a = base;
        if (cnt == 0) begin
            if (ld) erf[15] = mem_m[base[7:2]];
            else    emem[base[7:2]] = rf_m[15] + 32'd2;
        end else begin
            for (int k = 0; k < 8; k++) if (lst[k]) begin
                if (ld) erf[k] = mem_m[a[7:2]];
                else    emem[a[7:2]] = (k == b && k != low) ? fin : rf_m[k];
                a = a + 32'd4;
            end
        end
        erf[b] = fin;
        if (cnt == 0)        begin rtag = ld ? "R8" : "R9 base"; mtag = ld ? "R8 memory" : "R9"; end
        else if (ld)         begin rtag = lst[b] ? "R7" : "R3 R5"; mtag = "R3 memory untouched"; end
        else                 begin rtag = "R5"; mtag = lst[b] ? "R6" : "R4"; end
        if (inject) begin rtag = {rtag, " R12"}; mtag = {mtag, " R12"}; end

        exp_addr = base; exp_we = !ld; done_cnt = 0;
        @(negedge clk); #1;
        instr_i = {4'hC, ld, 3'(b), 8'(lst)};
        start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        if (inject) begin
            @(negedge clk); #1;
            if (busy_o) begin
                instr_i = {4'hC, !ld, 3'(b ^ 5), 8'(~lst)};
                start_i = 1'b1;
                @(negedge clk); #1;
                start_i = 1'b0;
            end
        end
        while (done_cnt == 0) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        @(negedge clk); #1;
        check_eq("R11 done pulses", 32'(done_cnt), 32'd1);
        check_eq("R11 busy after done", {31'd0, busy_o}, 32'd0);
        bad_r = -1; bad_m = -1;
        for (int i = 15; i >= 0; i--) if (rf_m[i] !== erf[i]) bad_r = i;
        for (int i = 63; i >= 0; i--) if (mem_m[i] !== emem[i]) bad_m = i;
        if (bad_r >= 0) check_eq({rtag, " regfile"}, rf_m[bad_r], erf[bad_r]);
        else            check_eq({rtag, " regfile"}, rf_m[b], erf[b]);
        if (bad_m >= 0) check_eq({mtag, " memory"}, mem_m[bad_m], emem[bad_m]);
        else            check_eq({mtag, " memory"}, mem_m[base[7:2]], emem[base[7:2]]);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: quiet state while and just after reset
        check_eq("R13 busy", {31'd0, busy_o}, 32'd0);
        check_eq("R13 done", {31'd0, done_o}, 32'd0);
        check_eq("R13 mem_req", {31'd0, mem_req_o}, 32'd0);
        check_eq("R13 rf_wr_en", {31'd0, rf_wr_en_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_eq("R13 idle after release", {31'd0, busy_o}, 32'd0);
        // Full sweep: both directions, every base, every list
        for (int ld = 0; ld < 2; ld++)
            for (int b = 0; b < 8; b++)
                for (int lst = 0; lst < 256; lst++)
                    run_op(ld[0], b, lst, (lst % 5) == 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule